// File: doc/BRIEF.md
# NAND Flash Bus Controller

This block connects a small memory-mapped register port to a raw 8-bit NAND flash bus. Software sets the command-latch, address-latch, chip-enable and chip-select levels in a mode register. It then moves bytes through a data register. Each data access that reaches the flash turns into one read or write strobe. The strobe width and the hold time that follows it are programmed in bus clocks.

While a strobe and its hold time are running, the register port stalls the requester with a ready signal. The flash ready/busy pin can be read back as a status flag. A self-clearing soft reset returns the mode and timing settings to their defaults. The flash data bus is given as separate output, output-enable and input vectors, so an I/O pad can be placed outside the block.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset all four chip-enable outputs are high. Command latch, address latch and the output enable are low, and both strobes are high. The mode register reads 0x00 and the timing register reads 0x11.
- R2: The mode register is at offset 0x04. Bit 7 is write enable, bit 4 is chip enable, bits [3:2] select the chip and bits 1 and 0 are address latch and command latch. The other bits are not stored, so writing 0xFF reads back 0x9F.
- R3: Chip enable set to 1 drives the selected active-low chip-enable output low and holds the other three high. Chip enable set to 0 holds all four high.
- R4: The command-latch and address-latch outputs follow mode bits 0 and 1.
- R5: The status register is at offset 0x08. Bit 7 reads 1 while the ready/busy pin is low (flash busy), after a two-clock synchronizer. All other status bits read 0.
- R6: The timing register is at offset 0x14. It holds the hold count in bits [7:4] and the strobe count in bits [3:0]. A field written as 0 is stored as 1.
- R7: A data-register write (offset 0x00) made while write enable is set drives the byte on the flash bus and pulls the write strobe low for strobe+1 clocks. The output enable stays high for a further hold+2 clocks. The byte and the latch levels are stable over the whole strobe.
- R8: A data-register write made while write enable is clear completes at once. It produces no strobe and does not drive the bus.
- R9: A data-register read pulls the read strobe low for strobe+1 clocks while the bus is not driven. It returns the byte present on the flash data input at the last strobe clock.
- R10: Ready stays low on a data access that reaches the flash. The access completes strobe+hold+4 clock edges after the request is presented. Accesses to the other registers complete with no stall.
- R11: Writing 1 to bit 0 at offset 0x18 starts a soft reset. The bit reads 1 until the reset finishes, then 0. The mode and timing registers return to their reset values, and no strobe happens during the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, held until ready |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while ready is high |
| reg_ready | output | 1 | Access completes in this cycle |
| fl_ce_n | output | 4 | Active-low chip enables |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_rb_n | input | 1 | Flash ready/busy, low while busy |

## Verification
Writes are sent as command, address and plain data bytes under three timing words: a mid setting, a narrow one and one with the largest hold. A scoreboard compares each strobe's byte, latch levels, width and hold against the programmed fields, which separates the +1 and +2 offsets and the two fields from each other. The stall length of every data access is compared as well. A data write with write enable clear must give an immediate completion and no strobe; any unexpected strobe fails in the monitor. Reads are checked for width, returned byte and latency, and register patterns such as 0xFF and zero timing fields expose masking and clamping.

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl #(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_req,
  input  logic       reg_wr,
  input  logic [4:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       reg_ready,
  output logic [3:0] fl_ce_n,
  output logic       fl_cle,
  output logic       fl_ale,
  output logic       fl_we_n,
  output logic       fl_re_n,
  output logic [7:0] fl_dq_o,
  output logic       fl_dq_oe,
  input  logic [7:0] fl_dq_i,
  input  logic       fl_rb_n
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [4:0] A_DATA = 5'h00, A_MODE = 5'h04, A_STAT = 5'h08,
                         A_TIME = 5'h14, A_RST = 5'h18;

  typedef enum logic [1:0] {S_IDLE, S_STB, S_HOLD, S_DONE} state_t;

  state_t         st;
  logic [7:0]     mode_q, wbyte, rbyte;
  logic [3:0]     hold_q, spw_q;
  logic [4:0]     cnt;
  logic           op_wr;
  logic [1:0]     busy_s;
  logic [RW-1:0]  rst_cnt;

  wire in_rst    = rst_cnt != '0;
  wire hit_data  = reg_req && reg_addr == A_DATA;
  wire data_live = hit_data && (!reg_wr || mode_q[7]);
  wire go        = st == S_IDLE && data_live && !in_rst;
  wire cfg_wr    = st == S_IDLE && reg_req && reg_wr && !hit_data;

  assign reg_ready = st == S_DONE || (st == S_IDLE && !data_live);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= '0; hold_q <= 4'd1; spw_q <= 4'd1; cnt <= '0;
      wbyte <= '0; rbyte <= '0; op_wr <= 1'b0; busy_s <= '0; rst_cnt <= '0;
    end else begin
      busy_s <= {busy_s[0], ~fl_rb_n};
      if (cfg_wr && reg_addr == A_RST && reg_wdata[0])
        rst_cnt <= RST_CYCLES[RW-1:0];
      else if (in_rst)
        rst_cnt <= rst_cnt - RW'(1);
      if (in_rst) begin
        mode_q <= '0; hold_q <= 4'd1; spw_q <= 4'd1;
      end else if (cfg_wr && reg_addr == A_MODE) begin
        mode_q <= reg_wdata & 8'h9F;
      end else if (cfg_wr && reg_addr == A_TIME) begin
        hold_q <= (reg_wdata[7:4] == 4'd0) ? 4'd1 : reg_wdata[7:4];
        spw_q  <= (reg_wdata[3:0] == 4'd0) ? 4'd1 : reg_wdata[3:0];
      end
      case (st)
        S_IDLE: if (go) begin
          st <= S_STB; cnt <= {1'b0, spw_q}; op_wr <= reg_wr; wbyte <= reg_wdata;
        end
        S_STB: if (cnt == '0) begin
          st <= S_HOLD; cnt <= {1'b0, hold_q} + 5'd1;
          if (!op_wr) rbyte <= fl_dq_i;
        end else cnt <= cnt - 5'd1;
        S_HOLD: if (cnt == '0) st <= S_DONE; else cnt <= cnt - 5'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_ce
    assign fl_ce_n[i] = !(mode_q[4] && mode_q[3:2] == 2'(i));
  end

  assign fl_cle   = mode_q[0];
  assign fl_ale   = mode_q[1];
  assign fl_we_n  = !(st == S_STB && op_wr);
  assign fl_re_n  = !(st == S_STB && !op_wr);
  assign fl_dq_oe = op_wr && (st == S_STB || st == S_HOLD);
  assign fl_dq_o  = wbyte;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rbyte;
      A_MODE:  reg_rdata = mode_q;
      A_STAT:  reg_rdata = {busy_s[1], 7'd0};
      A_TIME:  reg_rdata = {hold_q, spw_q};
      A_RST:   reg_rdata = {7'd0, in_rst};
      default: reg_rdata = 8'd0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_re_n)); // R9
  AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_re_n |-> !fl_dq_oe); // R9
  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~fl_ce_n)); // R3
  AST_STALL_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_re_n) |-> !reg_ready); // R10
  AST_WE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_dq_o) && $stable(fl_cle) && $stable(fl_ale))); // R7
  AST_QUIET_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |-> (fl_we_n && fl_re_n)); // R11
endmodule

// File: tb/nand_bus_ctrl_test.sv
`timescale 1ns/1ps
module nand_bus_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic reg_req = 0, reg_wr = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic reg_ready;
  logic [3:0] fl_ce_n;
  logic fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
  logic [7:0] fl_dq_o;
  logic [7:0] fl_dq_i = 8'h00;
  logic fl_rb_n = 1;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  nand_bus_ctrl uut (.*);

  typedef struct { logic [7:0] b; logic cle; logic ale; int w; int h; } exp_t;
  exp_t wq[$];
  int   rq[$];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [4:0] a, input logic w, input logic [7:0] d,
                     output logic [7:0] rd, output int stalls);
    @(negedge clk);
    reg_req = 1; reg_wr = w; reg_addr = a; reg_wdata = d; stalls = 0;
    forever begin
      #1;
      if (reg_ready) begin rd = reg_rdata; break; end
      stalls++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    reg_req = 0; reg_wr = 0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] rd; int s;
    bus(a, 1'b1, d, rd, s);
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] rd);
    int s;
    bus(a, 1'b0, 8'h00, rd, s);
  endtask

  task automatic flash_wr(input logic [7:0] b, input logic cle, input logic ale,
                          input int spw, input int hold);
    logic [7:0] rd; int s;
    exp_t e;
    e.b = b; e.cle = cle; e.ale = ale; e.w = spw + 1; e.h = hold + 2;
    wq.push_back(e);
    bus(5'h00, 1'b1, b, rd, s);
    chk("R10 write stall", s, spw + hold + 4);
  endtask

  // monitor: sampled at negedge, away from the active edge
  int wcnt = 0, hcnt = 0, rcnt = 0;
  logic [7:0] gb; logic gcle, gale;
  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (wcnt == 0) begin gb = fl_dq_o; gcle = fl_cle; gale = fl_ale; end
      wcnt++;
    end else if (wcnt != 0 && fl_dq_oe) begin
      hcnt++;
    end else if (wcnt != 0) begin
      if (wq.size() == 0) chk("R8 unexpected write strobe", 1, 0);
      else begin
        exp_t e;
        e = wq.pop_front();
        chk("R7 byte", gb, e.b);
        chk("R4 cle", gcle, e.cle);
        chk("R4 ale", gale, e.ale);
        chk("R7 strobe width", wcnt, e.w);
        chk("R7 hold", hcnt, e.h);
      end
      wcnt = 0; hcnt = 0;
    end
    if (!fl_re_n) begin
      rcnt++;
      if (fl_dq_oe) chk("R9 bus driven in read", 1, 0);
    end else if (rcnt != 0) begin
      if (rq.size() == 0) chk("R9 unexpected read strobe", 1, 0);
      else chk("R9 read width", rcnt, rq.pop_front());
      rcnt = 0;
    end
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 ce_n", fl_ce_n, 4'hF);
    chk("R1 cle", fl_cle, 0);
    chk("R1 ale", fl_ale, 0);
    chk("R1 we_n", fl_we_n, 1);
    chk("R1 re_n", fl_re_n, 1);
    chk("R1 oe", fl_dq_oe, 0);
    rd_reg(5'h04, rd); chk("R1 mode", rd, 8'h00);
    rd_reg(5'h14, rd); chk("R1 timing", rd, 8'h11);

    // R2 R3 R4
    wr_reg(5'h04, 8'hFF);
    rd_reg(5'h04, rd); chk("R2 mode mask", rd, 8'h9F);
    chk("R3 ce_n cs3", fl_ce_n, 4'b0111);
    chk("R4 cle on", fl_cle, 1);
    chk("R4 ale on", fl_ale, 1);
    wr_reg(5'h04, 8'h14);
    chk("R3 ce_n cs1", fl_ce_n, 4'b1101);
    chk("R4 cle off", fl_cle, 0);
    chk("R4 ale off", fl_ale, 0);
    wr_reg(5'h04, 8'h0C);
    chk("R3 ce off", fl_ce_n, 4'hF);

    // R5
    fl_rb_n = 0;
    repeat (3) @(negedge clk);
    bus(5'h08, 1'b0, 8'h00, rd, s);
    chk("R5 busy", rd, 8'h80);
    chk("R10 status no stall", s, 0);
    fl_rb_n = 1;
    repeat (3) @(negedge clk);
    rd_reg(5'h08, rd); chk("R5 ready", rd, 8'h00);

    // R6
    wr_reg(5'h14, 8'h00);
    rd_reg(5'h14, rd); chk("R6 zero clamps", rd, 8'h11);
    wr_reg(5'h14, 8'h32);
    rd_reg(5'h14, rd); chk("R6 readback", rd, 8'h32);

    // R8: write with write enable clear
    wr_reg(5'h04, 8'h11);
    bus(5'h00, 1'b1, 8'hAA, rd, s);
    chk("R8 no stall", s, 0);
    repeat (4) @(negedge clk);
    chk("R8 we_n idle", fl_we_n, 1);
    chk("R8 oe idle", fl_dq_oe, 0);

    // R7 command, address, data bytes
    wr_reg(5'h04, 8'h91);
    flash_wr(8'h70, 1, 0, 2, 3);
    wr_reg(5'h04, 8'h92);
    flash_wr(8'h12, 0, 1, 2, 3);
    wr_reg(5'h14, 8'h21);
    wr_reg(5'h04, 8'h90);
    flash_wr(8'h5A, 0, 0, 1, 2);
    wr_reg(5'h14, 8'hF1);
    flash_wr(8'hC6, 0, 0, 1, 15);
    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", wq.size(), 0);

    // R9 R10 read
    wr_reg(5'h14, 8'h32);
    wr_reg(5'h04, 8'h10);
    fl_dq_i = 8'hC3;
    rq.push_back(3);
    bus(5'h00, 1'b0, 8'h00, rd, s);
    chk("R9 read byte", rd, 8'hC3);
    chk("R10 read stall", s, 9);
    fl_dq_i = 8'h3C;
    wr_reg(5'h14, 8'h11);
    rq.push_back(2);
    bus(5'h00, 1'b0, 8'h00, rd, s);
    chk("R9 read byte 2", rd, 8'h3C);
    chk("R10 read stall 2", s, 6);
    repeat (2) @(negedge clk);
    chk("R9 scoreboard drained", rq.size(), 0);

    // R11 soft reset
    wr_reg(5'h04, 8'h9F);
    wr_reg(5'h14, 8'h77);
    wr_reg(5'h18, 8'h01);
    rd_reg(5'h18, rd); chk("R11 in progress", rd, 8'h01);
    repeat (8) @(negedge clk);
    rd_reg(5'h18, rd); chk("R11 self clear", rd, 8'h00);
    rd_reg(5'h04, rd); chk("R11 mode restored", rd, 8'h00);
    rd_reg(5'h14, rd); chk("R11 timing restored", rd, 8'h11);
    chk("R11 ce_n", fl_ce_n, 4'hF);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule